// File: doc/BRIEF.md
# Radix-4 Recoded Sequential Signed Multiplier

This block multiplies two two's-complement operands over several clock cycles. The multiplier operand is recoded in radix 4. In each cycle the block takes one overlapping window of three multiplier bits and turns it into a digit from the set {-2, -1, 0, +1, +2}. The matching multiple of the multiplicand is then added into a wide running sum, and the running sum moves two bit positions to the right. Because each step retires two multiplier bits, an operand of width WD needs only WD/2 add/subtract steps.

A client presents both operands and pulses `start` while the block is idle. The block samples the operands on that edge. After the last step it raises `done` for exactly one cycle and shows the full double-width signed product. That product stays on the output until the next accepted start. A start that arrives while a multiplication is running is ignored.

Top module: `booth4_seq_mul`

## Requirements
- R1: While reset is low, and afterwards until the first accepted start, `done` reads 0 and `product` reads 0.
- R2: A start sampled high while the block is idle is accepted. `done` goes high WD/2 rising edges after the edge that sampled the start.
- R3: When `done` is high, `product` equals the exact signed product of `op_a` and `op_b` as they were sampled on the accepting edge. The result is 2*WD bits wide.
- R4: `done` stays high for one cycle only. It is low in the cycle after any cycle in which it is high.
- R5: While a multiplication runs, `start` pulses and changes on `op_a` or `op_b` have no effect on the result or on the timing of `done`.
- R6: The multiplier is scanned in windows of three bits {b[2i+1], b[2i], b[2i-1]}, with b[-1] taken as 0. The windows map to digits as follows: 000 and 111 give 0; 001 and 010 give +1; 011 gives +2; 100 gives -2; 101 and 110 give -1. The product is correct for multiplier patterns that produce every digit value.
- R7: When both operands are the most negative value, the product is +2^(2*WD-2), with no overflow of the internal sum.
- R8: After `done`, `product` holds its value for as long as no start is accepted.
- R9: A start presented in the same cycle as `done` is accepted. The next result follows the timing of R2.
- R10: WD must be even and at least 2. Any other value is rejected at elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to begin a multiplication; acted on only when idle |
| op_a | input | WD | Signed multiplicand |
| op_b | input | WD | Signed multiplier, recoded in radix 4 |
| done | output | 1 | One-cycle pulse marking a valid product |
| product | output | 2*WD | Signed product |

## Verification
Two events can fall in the same cycle: the completion pulse of one multiplication and the acceptance of the next start. The bench provokes this by issuing a new request in the very cycle it sees `done`. It then checks two things: that `done` drops in the following cycle, and that the second product appears exactly WD/2 edges later with the right value. A second collision is a start that arrives while a multiplication is still running, together with new operand values. For this case the bench checks that neither the timing nor the value of the result in flight changes.

// File: rtl/booth4_pkg.sv
package booth4_pkg;
   // One radix-4 digit: magnitude selects (one / two) and a sign.
   typedef struct packed {
      logic neg;
      logic one;
      logic two;
   } booth_dig_t;
endpackage

// File: rtl/booth4_recoder.sv
module booth4_recoder
   import booth4_pkg::*;
(
   input  logic [2:0]  win,
   output booth_dig_t  dig
);
   // win = {upper bit, middle bit, lower (overlap) bit}
   always_comb begin
      dig = '{neg: 1'b0, one: 1'b0, two: 1'b0};
      unique case (win)
         3'b000, 3'b111: dig = '{neg: 1'b0, one: 1'b0, two: 1'b0};
         3'b001, 3'b010: dig = '{neg: 1'b0, one: 1'b1, two: 1'b0};
         3'b011:         dig = '{neg: 1'b0, one: 1'b0, two: 1'b1};
         3'b100:         dig = '{neg: 1'b1, one: 1'b0, two: 1'b1};
         3'b101, 3'b110: dig = '{neg: 1'b1, one: 1'b1, two: 1'b0};
         default:        dig = '{neg: 1'b0, one: 1'b0, two: 1'b0};
      endcase
   end
endmodule

// File: rtl/booth4_pp_sel.sv
module booth4_pp_sel
   import booth4_pkg::*;
#(
   parameter int WD = 16,
   localparam int PW = WD + 2
)(
   input  logic [WD-1:0] mcand,
   input  booth_dig_t    dig,
   output logic [PW-1:0] pp
);
   logic [PW-1:0] ext;
   logic [PW-1:0] mag;

   assign ext = {{2{mcand[WD-1]}}, mcand};

   always_comb begin
      if (dig.two)      mag = {ext[PW-2:0], 1'b0};
      else if (dig.one) mag = ext;
      else              mag = '0;
      pp = dig.neg ? (~mag + {{(PW-1){1'b0}}, 1'b1}) : mag;
   end
endmodule

// File: rtl/booth4_ctrl.sv
module booth4_ctrl #(
   parameter int STEPS = 8,
   localparam int CW = (STEPS > 1) ? $clog2(STEPS) : 1
)(
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic load,
   output logic done
);
   logic [CW-1:0] cnt;
   logic          last;

   assign load = start & ~busy;
   assign last = busy & (cnt == CW'(STEPS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cnt  <= '0;
         done <= 1'b0;
      end else begin
         done <= last;
         if (load) begin
            busy <= 1'b1;
            cnt  <= '0;
         end else if (busy) begin
            cnt <= cnt + 1'b1;
            if (last) busy <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/booth4_seq_mul.sv
module booth4_seq_mul
   import booth4_pkg::*;
#(
   parameter int WD = 16
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [WD-1:0]   op_a,
   input  logic [WD-1:0]   op_b,
   output logic            done,
   output logic [2*WD-1:0] product
);
   localparam int STEPS = WD / 2;
   localparam int HW    = WD + 2;

   // R10: elaboration-time width check
   generate
      if ((WD % 2) != 0 || WD < 2) begin : g_wd_bad
         $error("booth4_seq_mul: WD must be even and >= 2");
      end
   endgenerate

   logic            busy;
   logic            load;
   logic [HW-1:0]   hi;
   logic [WD-1:0]   lo;
   logic            q;
   logic [WD-1:0]   mcand;
   logic [HW-1:0]   pp;
   logic [HW-1:0]   sum;
   booth_dig_t      dig;

   booth4_ctrl #(.STEPS(STEPS)) u_ctrl (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .busy  (busy),
      .load  (load),
      .done  (done)
   );

   booth4_recoder u_rec (
      .win (lo[1:0] == 2'b00 ? {2'b00, q} : {lo[1:0], q}),
      .dig (dig)
   );

   booth4_pp_sel #(.WD(WD)) u_pp (
      .mcand (mcand),
      .dig   (dig),
      .pp    (pp)
   );

   assign sum = hi + pp;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi    <= '0;
         lo    <= '0;
         q     <= 1'b0;
         mcand <= '0;
      end else if (load) begin
         hi    <= '0;
         lo    <= op_b;
         q     <= 1'b0;
         mcand <= op_a;
      end else if (busy) begin
         hi <= {{2{sum[HW-1]}}, sum[HW-1:2]};
         lo <= {sum[1:0], lo[WD-1:2]};
         q  <= lo[1];
      end
   end

   assign product = {hi[WD-1:0], lo};
endmodule

// File: rtl/booth4_seq_mul_chk.sv
module booth4_seq_mul_chk #(
   parameter int WD = 16
)(
   input logic            clk,
   input logic            rst_n,
   input logic            start,
   input logic            busy,
   input logic [WD-1:0]   op_a,
   input logic [WD-1:0]   op_b,
   input logic            done,
   input logic [2*WD-1:0] product
);
   localparam int STEPS = WD / 2;
   localparam int KW    = $clog2(STEPS + 1) + 1;

   logic signed [WD-1:0]   a_q, b_q;
   logic signed [2*WD-1:0] exp_p;
   logic [KW-1:0]          cyc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_q <= '0;
         b_q <= '0;
         cyc <= '0;
      end else if (start && !busy) begin
         a_q <= op_a;
         b_q <= op_b;
         cyc <= '0;
      end else if (cyc < KW'(STEPS)) begin
         cyc <= cyc + 1'b1;
      end
   end

   assign exp_p = (2*WD)'(a_q) * (2*WD)'(b_q);

   // R2
   done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (cyc == KW'(STEPS)));

   // R3
   done_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (product == exp_p));

   // R4
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R8
   product_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> $stable(product));
endmodule

bind booth4_seq_mul booth4_seq_mul_chk #(.WD(WD)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .start   (start),
   .busy    (busy),
   .op_a    (op_a),
   .op_b    (op_b),
   .done    (done),
   .product (product)
);

// File: tb/booth4_seq_mul_tb.sv
module booth4_seq_mul_tb;
   localparam int WD     = 16;
   localparam int STEPS  = WD / 2;
   localparam int PERIOD = 10;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            start = 1'b0;
   logic [WD-1:0]   op_a = '0;
   logic [WD-1:0]   op_b = '0;
   logic            done;
   logic [2*WD-1:0] product;

   int checks = 0;
   int errors = 0;

   always #(PERIOD/2) clk = ~clk;

   booth4_seq_mul #(.WD(WD)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start),
      .op_a(op_a), .op_b(op_b), .done(done), .product(product)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [2*WD-1:0] ref_mul(input logic [WD-1:0] a, input logic [WD-1:0] b);
      logic signed [2*WD-1:0] sa, sb;
      sa = (2*WD)'($signed(a));
      sb = (2*WD)'($signed(b));
      return sa * sb;
   endfunction

   // Caller sits just after a falling edge. Returns number of falling edges until done.
   task automatic run_mul(input logic [WD-1:0] a, input logic [WD-1:0] b, input string req);
      int n = 0;
      op_a  = a;
      op_b  = b;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (n < 4*STEPS) begin
         @(negedge clk);
         n++;
         if (done) break;
      end
      chk(n == STEPS, {req, " R2 latency"}, 64'(n), 64'(STEPS));
      chk(product == ref_mul(a, b), {req, " R3 value"}, 64'(product), 64'(ref_mul(a, b)));
   endtask

   task automatic t_reset;
      chk(done == 1'b0, "R1 done in reset", 64'(done), 0);
      chk(product == '0, "R1 product in reset", 64'(product), 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      @(negedge clk);
      chk(done == 1'b0, "R1 done idle", 64'(done), 0);
      chk(product == '0, "R1 product idle", 64'(product), 0);
   endtask

   task automatic t_digits;
      // R6: patterns exercising all digit values
      run_mul(16'h1234, 16'h5555, "R6 5555");
      run_mul(16'h1234, 16'hAAAA, "R6 AAAA");
      run_mul(16'hF00D, 16'h3333, "R6 3333");
      run_mul(16'h7FFF, 16'hCCCC, "R6 CCCC");
      run_mul(16'h8001, 16'h6DB6, "R6 6DB6");
      run_mul(16'h0003, 16'h7FFF, "R6 7FFF");
   endtask

   task automatic t_extremes;
      // R7
      run_mul(16'h8000, 16'h8000, "R7 min*min");
      chk(product == 32'h4000_0000, "R7 min*min const", 64'(product), 64'h4000_0000);
      run_mul(16'h8000, 16'h7FFF, "R7 min*max");
      run_mul(16'hFFFF, 16'hFFFF, "R3 -1*-1");
      run_mul(16'h0000, 16'h8000, "R3 0*min");
   endtask

   task automatic t_pulse_hold;
      logic [2*WD-1:0] held;
      run_mul(16'h0123, 16'hFEDC, "R4 run");
      held = product;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         if (i == 0) chk(done == 1'b0, "R4 done drops", 64'(done), 0);
         chk(product == held, "R8 hold", 64'(product), 64'(held));
      end
   endtask

   task automatic t_busy_ignore;
      int n = 0;
      op_a  = 16'h2345;
      op_b  = 16'hC001;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (n < 4*STEPS) begin
         @(negedge clk);
         n++;
         if (done) break;
         // R5: disturb inputs while running
         if (n < STEPS - 2) begin
            start = 1'b1;
            op_a  = 16'(n * 16'h1111);
            op_b  = 16'(16'h8000 + n);
         end else begin
            start = 1'b0;
         end
      end
      start = 1'b0;
      chk(n == STEPS, "R5 latency", 64'(n), 64'(STEPS));
      chk(product == ref_mul(16'h2345, 16'hC001), "R5 value",
          64'(product), 64'(ref_mul(16'h2345, 16'hC001)));
   endtask

   task automatic t_back_to_back;
      // R9: second start issued in the done cycle of the first
      run_mul(16'h4321, 16'h9876, "R9 first");
      run_mul(16'hABCD, 16'h0F0F, "R9 second");
      run_mul(16'h7FFF, 16'h8000, "R9 third");
   endtask

   task automatic t_random;
      logic [31:0] lf = 32'hACE1_2468;
      for (int i = 0; i < 30; i++) begin
         lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
         lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
         run_mul(lf[15:0], lf[31:16], "R3 random");
      end
   endtask

   initial begin
      #(PERIOD * 150000);
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      @(negedge clk);
      t_reset();
      t_digits();
      t_extremes();
      t_pulse_hold();
      t_busy_ignore();
      t_back_to_back();
      t_random();
      repeat (3) @(negedge clk);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule